// File: doc/BRIEF.md
# DC-Balanced Embedded-Clock Frame Serializer

This block turns a stream of 24-bit parallel words into a single serial line. Each word is packed into a 28-bit frame, and the block sends one frame bit per bit-clock cycle. The bit clock runs at 28 times the word rate. Every frame opens with a fixed 1 and closes with a fixed 0, so each frame holds one guaranteed rising transition that a receiver can lock its clock to. The payload is sent either unchanged or with every bit inverted. The choice is made for each word so that the line stays close to DC-neutral, which lets the link be AC-coupled. A control bit tells the receiver which choice was made, and a parity bit lets the receiver check each frame.

The parallel clock is an ordinary input, sampled in the bit-clock domain. An edge-select input picks whether words are taken on its rising or its falling edge. The serial output is gated by three conditions: the active-low power-down input, the output enable, and a PLL-lock status input. A separate enable flag stands in for the tri-state control of the line driver.

Top module: `dcbal_frame_ser`

## Requirements
- R1: While running (`pd_n` and `pll_locked` both high), frames of exactly 28 bits follow back to back, one bit per `clk` cycle. The first frame starts in the first cycle after the clock edge at which running is seen.
- R2: Line position 1 of every frame (the first bit sent) is 1, and position 28 (the last bit sent) is 0.
- R3: Positions 2 to 13 carry sent payload bits 0 to 11 in ascending order. Position 14 is the parity bit and position 15 is the invert flag. Positions 16 to 27 carry sent payload bits 12 to 23 in ascending order. The sent payload is the word XOR the invert flag.
- R4: A word's disparity is 2·(number of ones) − 24. The word is inverted exactly when its disparity and the running disparity are both positive or both negative. The running disparity then adds the disparity of the payload actually sent. It starts at 0.
- R5: The parity bit makes the number of ones across the 24 sent payload bits plus the invert flag even.
- R6: With `edge_rise` high, `par_data` is captured on a 0→1 change of `par_clk`. With `edge_rise` low, it is captured on a 1→0 change. A frame carries the word most recently captured before the clock edge at which the frame is loaded.
- R7: While `pd_n` is low, `ser_oe` and `ser_out` are 0, the frame phase is abandoned and the running disparity returns to 0. When `pd_n` rises, a fresh frame starts as in R1.
- R8: While `out_en` is low, `ser_oe` and `ser_out` are 0, but frames and the running disparity keep advancing. When `out_en` returns high, output resumes in the middle of the frame currently in progress.
- R9: While `pll_locked` is low, the behaviour is as in R7. The output stays disabled until lock is reported again.
- R10: During reset, `ser_oe` and `ser_out` are 0. After reset the running disparity is 0 and the held word is 0.
- R11: `ser_out` is 0 whenever `ser_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, 28 times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_clk | input | 1 | Parallel word clock, sampled in the `clk` domain |
| par_data | input | 24 | Parallel data word |
| edge_rise | input | 1 | 1: capture on rising `par_clk`; 0: capture on falling `par_clk` |
| pd_n | input | 1 | Active-low power-down; low stops framing |
| out_en | input | 1 | Output enable; low disables the line but framing continues |
| pll_locked | input | 1 | PLL lock status; low stops framing |
| ser_out | output | 1 | Serial frame bit, first bit is the fixed 1 |
| ser_oe | output | 1 | Line driver enable (models tri-state) |

## Verification
Any wrong internal state reaches the serial line within one frame. A wrong invert decision or a corrupted running disparity shows up at position 15 of the next frame loaded. It also changes every payload bit of that frame, and it changes the decisions of all later frames. A wrong capture edge, or a stale held word, puts the wrong payload into the next frame. A frame counter that slips moves the fixed 1 and 0 away from positions 1 and 28 at once. A fault in the gating shows on `ser_oe` in the very cycle that `pd_n`, `out_en` or `pll_locked` changes, or in the cycle after it. The bench compares both outputs with a behavioural model on every clock, so any of these faults is caught within at most 28 cycles.

// File: rtl/dcbal_frame_ser.sv
module dcbal_frame_ser #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_clk,
  input  logic [WORD_W-1:0] par_data,
  input  logic              edge_rise,
  input  logic              pd_n,
  input  logic              out_en,
  input  logic              pll_locked,
  output logic              ser_out,
  output logic              ser_oe
);
  localparam int FRAME_W = WORD_W + 4;
  localparam int HALF    = WORD_W / 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int RD_W    = $clog2(WORD_W + 1) + 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic                    pclk_q;
  logic [WORD_W-1:0]       word_q;
  logic [CNT_W-1:0]        cnt;
  logic                    live;
  logic signed [RD_W-1:0]  rd;
  logic [FRAME_W-1:0]      frm;

  function automatic logic signed [RD_W-1:0] disp_of(input logic [WORD_W-1:0] w);
    int n;
    n = 0;
    for (int i = 0; i < WORD_W; i++) n += int'(w[i]);
    return RD_W'(2 * n - WORD_W);
  endfunction

  wire run = pd_n & pll_locked;
  wire cap = edge_rise ? (par_clk & ~pclk_q) : (~par_clk & pclk_q);

  logic signed [RD_W-1:0] wdisp;
  logic                   flip;
  logic [WORD_W-1:0]      sent;
  logic                   dca;
  logic [FRAME_W-1:0]     nf;

  assign wdisp = disp_of(word_q);
  assign flip  = (rd > 0 && wdisp > 0) || (rd < 0 && wdisp < 0);
  assign sent  = word_q ^ {WORD_W{flip}};
  assign dca   = ^{sent, flip};

  assign nf[FRAME_W-1] = 1'b1;
  assign nf[HALF+2]    = dca;
  assign nf[HALF+1]    = flip;
  assign nf[0]         = 1'b0;
  for (genvar i = 0; i < HALF; i++) begin : g_pack
    assign nf[FRAME_W-2-i]      = sent[i];
    assign nf[FRAME_W-4-HALF-i] = sent[HALF+i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
      word_q <= '0;
    end else begin
      pclk_q <= par_clk;
      if (cap) word_q <= par_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= LAST;
      live <= 1'b0;
      rd   <= '0;
      frm  <= '0;
    end else if (!run) begin
      cnt  <= LAST;
      live <= 1'b0;
      rd   <= '0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      live <= 1'b1;
      frm  <= nf;
      rd   <= rd + (flip ? -wdisp : wdisp);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ser_oe  = run & out_en & live;
  assign ser_out = ser_oe & frm[LAST - cnt];

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  p_frame_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && live && cnt != LAST) |=> $stable(frm));
  p_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (frm[FRAME_W-1] && !frm[0]));
  p_rd_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd <= RD_W'(WORD_W)) && (rd >= -RD_W'(WORD_W)));
  p_even_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (^frm[FRAME_W-2:1] == 1'b0));
  p_pd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !ser_oe);
  p_lock_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |=> (!ser_oe && !ser_out));
endmodule

// File: tb/dcbal_frame_ser_bench.sv
module dcbal_frame_ser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        par_clk = 1'b0;
  logic [23:0] par_data = '0;
  logic        edge_rise = 1'b1;
  logic        pd_n = 1'b1;
  logic        out_en = 1'b1;
  logic        pll_locked = 1'b1;
  logic        ser_out, ser_oe;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";
  int    pat_mode = 0;
  int    pat_k = 0;
  bit    done = 0;

  always #10 clk = ~clk;

  dcbal_frame_ser u_dcbal_frame_ser (
    .clk(clk), .rst_n(rst_n), .par_clk(par_clk), .par_data(par_data),
    .edge_rise(edge_rise), .pd_n(pd_n), .out_en(out_en),
    .pll_locked(pll_locked), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  bit          m_prev;
  logic [23:0] m_word;
  int          m_rd;
  bit          q[$];

  task automatic build_frame();
    int n, d;
    bit inv, par;
    logic [23:0] s;
    n = 0;
    for (int i = 0; i < 24; i++) if (m_word[i]) n++;
    d = 2 * n - 24;
    inv = (m_rd > 0 && d > 0) || (m_rd < 0 && d < 0);  // R4
    s = inv ? ~m_word : m_word;
    m_rd += inv ? -d : d;
    par = inv;
    for (int i = 0; i < 24; i++) par ^= s[i];           // R5
    q.delete();
    q.push_back(1'b1);                                   // R2
    for (int i = 0; i < 12; i++) q.push_back(s[i]);      // R3
    q.push_back(par);
    q.push_back(inv);
    for (int i = 12; i < 24; i++) q.push_back(s[i]);
    q.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev = 0; m_word = '0; m_rd = 0; q.delete();
    end else begin
      if (pd_n && pll_locked) begin                      // R1
        if (q.size() <= 1) build_frame();
        else void'(q.pop_front());
      end else begin                                     // R7 R9
        q.delete(); m_rd = 0;
      end
      if (edge_rise ? (par_clk && !m_prev) : (!par_clk && m_prev)) m_word = par_data; // R6
      m_prev = par_clk;
    end
  end

  always @(negedge clk) begin
    bit eo, ev;
    if (!done) begin
      eo = pd_n && pll_locked && out_en && (q.size() > 0);  // R8
      ev = eo ? q[0] : 1'b0;                                 // R11
      checks++;
      if (ser_oe !== eo || ser_out !== ev) begin
        errors++;
        $display("FAIL %s pos %0d oe act %b exp %b out act %b exp %b",
                 cur_req, 29 - q.size(), ser_oe, eo, ser_out, ev);
      end
    end
  end

  function automatic logic [23:0] next_word(int mode, int k, int pc);
    logic [23:0] v;
    case (mode)
      0: v = 24'hFFFFFF;
      1: v = k[0] ? 24'h555555 : 24'hAAAAAA;
      2: begin
        v = 24'hACE1B5;
        for (int i = 0; i < k % 97 + 1; i++) v = {v[22:0], v[23] ^ v[22] ^ v[21] ^ v[16]};
      end
      3: v = (pc < 14) ? 24'h0F00F3 ^ 24'(k) : 24'hF0FF0C ^ 24'(k << 4);
      default: v = (24'h1 << (k % 24)) - 24'h1;
    endcase
    return v;
  endfunction

  initial begin : par_gen
    int pc;
    pc = 0;
    wait (rst_n);
    forever begin
      @(posedge clk); #2;
      pc = (pc + 1) % 28;
      if (pc == 0) par_clk = 1'b1;
      if (pc == 14) par_clk = 1'b0;
      if (pc == 7 || pc == 21) begin
        pat_k++;
        par_data = next_word(pat_mode, pat_k, pc);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
    $finish;
  end

  initial begin : main
    // R10: reset state explicitly checked
    repeat (3) @(negedge clk);
    checks++;
    if (ser_oe !== 1'b0 || ser_out !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset oe %b out %b exp 0 0", ser_oe, ser_out);
    end
    @(posedge clk); #2; rst_n = 1'b1;
    cur_req = "R1 R2 R3"; pat_mode = 2; wait_cyc(600);
    cur_req = "R4"; pat_mode = 0; wait_cyc(400);
    cur_req = "R4"; pat_mode = 1; wait_cyc(400);
    cur_req = "R6"; pat_mode = 3; edge_rise = 1'b0; wait_cyc(600);
    cur_req = "R6"; edge_rise = 1'b1; wait_cyc(300);
    cur_req = "R8"; pat_mode = 2; wait_cyc(13); out_en = 1'b0; wait_cyc(200);
    out_en = 1'b1; wait_cyc(300);
    cur_req = "R7"; wait_cyc(9); pd_n = 1'b0; wait_cyc(100);
    pd_n = 1'b1; wait_cyc(400);
    cur_req = "R9"; wait_cyc(17); pll_locked = 1'b0; wait_cyc(60);
    pll_locked = 1'b1; wait_cyc(5); pll_locked = 1'b0; wait_cyc(3);
    pll_locked = 1'b1; wait_cyc(300);
    cur_req = "R11 R5"; pat_mode = 4; out_en = 1'b0; wait_cyc(50);
    out_en = 1'b1; wait_cyc(600);
    done = 1;
    summary();
    $finish;
  end
endmodule